// File: doc/BRIEF.md
# Burst Synchronous Static RAM

This block is a synthesizable behavioural model of a synchronous static RAM with a built-in burst sequencer. Each word has four 9-bit byte lanes, and the depth is set by a parameter. All control inputs are sampled on the rising clock edge. A burst starts from either of two address strobes. The processor strobe always begins a read and is gated by the master enable. The controller strobe is not gated by the master enable, and it samples the write enables on its own edge, so it can begin a read or a write.

Once a burst is open, the advance input steps the two low address bits through a four-beat sequence. The sequence is interleaved (XOR) or linear (add, wrapping within four) depending on a static mode pin. Reads leave through either a two-register pipelined path or a one-register flow-through path. The tri-state output is modelled as a data bus plus a drive-enable. A sleep input freezes everything and keeps the memory contents.

Top module: `burst_sram`

## Requirements
- R1: A strobe edge selects the device only when ce0_n is low, ce1 is high and ce2_n is low. A strobe edge with any enable inactive ends the burst, and the output stops driving.
- R2: With ce0_n high, adsp_n low has no effect and the open burst continues at its current address. adsc_n low with ce0_n high is a deselect.
- R3: A burst started by adsp_n low (with ce0_n low) is a read. The write enables are ignored on that edge, even when adsc_n is also low.
- R4: adsc_n low with adsp_n high and the device selected loads addr. On the same edge it writes when the write enables request a write.
- R5: gwe_n low writes all lanes whatever bwe_n and bw_n are. Lane i occupies din/dout bits [9i+8:9i], and bw_n[i] controls lane i.
- R6: With gwe_n high and bwe_n low, exactly the lanes whose bw_n bit is low are written. With bwe_n high, or no bw_n bit low, the cycle is a read and memory is unchanged.
- R7: With no strobe, adv_n low moves to the next burst address and adv_n high re-accesses the current one. The upper address bits stay fixed. The low two bits are start XOR count when lbo_n is high, and start plus count modulo 4 when lbo_n is low.
- R8: With ft_n high (pipelined), data for the access sampled at edge k is valid on dout after edge k+1.
- R9: With ft_n low (flow-through), data for the access sampled at edge k is valid on dout after edge k itself.
- R10: dout_en is high only while oe_n is low, and it follows oe_n without waiting for a clock edge.
- R11: An edge that samples any bw_n bit low, other than an edge that starts a processor-strobe burst, turns dout_en off for the following cycle whatever oe_n is.
- R12: In pipelined mode a deselect sampled at edge k leaves dout_en low after edge k+1.
- R13: While zz is high, dout_en is low and no state or memory word changes. After zz falls, the open burst resumes where it stopped.
- R14: After reset no burst is open and dout_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of control state |
| ce0_n | input | 1 | Master chip enable, active low; gates the processor strobe |
| ce1 | input | 1 | Chip enable, active high |
| ce2_n | input | 1 | Chip enable, active low |
| adsp_n | input | 1 | Processor address strobe, read-only start |
| adsc_n | input | 1 | Controller address strobe, read or write start |
| adv_n | input | 1 | Burst advance |
| gwe_n | input | 1 | Global write, all lanes |
| bwe_n | input | 1 | Enables per-lane writes |
| bw_n | input | 4 | Per-lane write enables |
| oe_n | input | 1 | Asynchronous output enable |
| ft_n | input | 1 | Low selects the flow-through read path |
| lbo_n | input | 1 | High: interleaved order; low: linear order |
| zz | input | 1 | Sleep, freezes state |
| addr | input | ADDR_W | Word address |
| din | input | 36 | Write data |
| dout | output | 36 | Read data, zero when not driven |
| dout_en | output | 1 | Output drive enable |

## Verification
The bench starts a burst at a start offset of 1. There the interleaved and linear orders differ, so a sequencer that ignored lbo_n, or that carried into the upper bits, would return the wrong words. It checks the processor strobe with write enables and the controller strobe held low at the same time; a design that let either win would corrupt memory. A processor strobe with ce0_n high is issued during an open burst, and a model that loaded the new address would return the wrong word. The bench also checks pipeline and flow-through latency beat by beat, the one-cycle deselect tail, lane masking, the per-lane blanking of the output, and that sleep leaves the burst exactly where it stopped.

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ce0_n,
  input  logic                      ce1,
  input  logic                      ce2_n,
  input  logic                      adsp_n,
  input  logic                      adsc_n,
  input  logic                      adv_n,
  input  logic                      gwe_n,
  input  logic                      bwe_n,
  input  logic [LANES-1:0]          bw_n,
  input  logic                      oe_n,
  input  logic                      ft_n,
  input  logic                      lbo_n,
  input  logic                      zz,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [LANES*LANE_W-1:0]   din,
  output logic [LANES*LANE_W-1:0]   dout,
  output logic                      dout_en
);
  localparam int WORD_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  logic              active;
  logic [ADDR_W-1:0] base;
  logic [1:0]        cnt;
  logic [ADDR_W-1:0] acc_addr;
  logic              acc_rd;
  logic [WORD_W-1:0] out_q;
  logic              out_v;
  logic              bw_blank;

  function automatic logic [1:0] seq_lo(input logic il, input logic [1:0] b, input logic [1:0] c);
    return il ? (b ^ c) : (b + c);
  endfunction

  wire sel      = !ce0_n && ce1 && !ce2_n;
  wire strobe_p = !adsp_n && !ce0_n;
  wire strobe_c = !adsc_n && !strobe_p;
  wire strobe   = strobe_p || strobe_c;

  logic [LANES-1:0] we_req;
  always_comb begin
    if (!gwe_n)      we_req = '1;
    else if (!bwe_n) we_req = ~bw_n;
    else             we_req = '0;
  end

  wire [1:0]        cnt_nx     = adv_n ? cnt : cnt + 2'd1;
  wire [ADDR_W-1:0] burst_addr = {base[ADDR_W-1:2], seq_lo(lbo_n, base[1:0], cnt_nx)};

  wire go_new  = !zz && strobe && sel;
  wire go_cont = !zz && !strobe && active;
  wire go      = go_new || go_cont;
  wire [ADDR_W-1:0] tgt = go_new ? addr : burst_addr;
  wire is_wr   = (go_new && strobe_c && |we_req) || (go_cont && |we_req);

  logic [LANES-1:0] lane_we;
  assign lane_we = is_wr ? we_req : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      base     <= '0;
      cnt      <= '0;
      acc_addr <= '0;
      acc_rd   <= 1'b0;
      out_v    <= 1'b0;
      bw_blank <= 1'b0;
    end else if (!zz) begin
      if (strobe) begin
        active <= sel;
        if (sel) begin
          base <= addr;
          cnt  <= '0;
        end
      end else if (active) begin
        cnt <= cnt_nx;
      end
      acc_rd   <= go && !is_wr;
      if (go) acc_addr <= tgt;
      out_v    <= acc_rd;
      bw_blank <= !strobe_p && |(~bw_n);
    end
  end

  always_ff @(posedge clk) begin
    if (!zz) out_q <= mem[acc_addr];
    for (int l = 0; l < LANES; l++)
      if (lane_we[l]) mem[tgt][l*LANE_W +: LANE_W] <= din[l*LANE_W +: LANE_W];
  end

  wire              rd_vis  = ft_n ? out_v : acc_rd;
  wire [WORD_W-1:0] rd_data = ft_n ? out_q : mem[acc_addr];

  assign dout_en = rd_vis && !oe_n && !bw_blank && !zz;
  assign dout    = dout_en ? rd_data : '0;

  // R3
  adsp_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!zz && !adsp_n && !ce0_n) |-> (lane_we == '0));

  // R4
  adsc_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!zz && adsp_n && !adsc_n && !ce0_n && ce1 && !ce2_n && !gwe_n) |-> (lane_we == '1));

  // R2
  adsc_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!zz && !adsc_n && ce0_n) |=> !acc_rd);

  // R11
  bw_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!zz && adsp_n && |(~bw_n)) |=> !dout_en);

  // R13
  zz_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zz |=> ($stable(acc_addr) && $stable(active) && $stable(cnt) && $stable(out_v)));
endmodule

// File: tb/burst_sram_tb.sv
module burst_sram_tb;
  localparam int AW = 6;
  localparam int WW = 36;

  logic clk = 1'b0;
  logic rst_n, ce0_n, ce1, ce2_n, adsp_n, adsc_n, adv_n, gwe_n, bwe_n, oe_n, ft_n, lbo_n, zz;
  logic [3:0]    bw_n;
  logic [AW-1:0] addr;
  logic [WW-1:0] din;
  logic [WW-1:0] dout;
  logic          dout_en;

  int checks = 0;
  int errors = 0;
  logic [WW-1:0] exp_mem [1 << AW];

  burst_sram u_dut (
    .clk(clk), .rst_n(rst_n), .ce0_n(ce0_n), .ce1(ce1), .ce2_n(ce2_n),
    .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n), .gwe_n(gwe_n), .bwe_n(bwe_n),
    .bw_n(bw_n), .oe_n(oe_n), .ft_n(ft_n), .lbo_n(lbo_n), .zz(zz),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
  );

  always #10 clk = ~clk;

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(20 * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  task automatic check_out(input string req, input logic en, input logic [WW-1:0] d);
    logic [WW:0] act, exp;
    act = {dout_en, dout};
    exp = {en, en ? d : {WW{1'b0}}};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual en=%b data=%h expected en=%b data=%h", req, act[WW], act[WW-1:0], exp[WW], exp[WW-1:0]);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_in;
    adsp_n = 1; adsc_n = 1; adv_n = 1; gwe_n = 1; bwe_n = 1; bw_n = 4'hf;
    ce0_n = 0; ce1 = 1; ce2_n = 0;
  endtask

  task automatic deselect;
    idle_in(); adsc_n = 0; ce0_n = 1; tick();
    idle_in(); tick();
  endtask

  function automatic logic [AW-1:0] seq_addr(input logic [AW-1:0] a, input int i, input logic il);
    logic [1:0] c;
    c = 2'(i);
    return {a[AW-1:2], il ? (a[1:0] ^ c) : (a[1:0] + c)};
  endfunction

  task automatic wr_burst(input logic [AW-1:0] a, input logic il, input logic [WW-1:0] seed);
    lbo_n = il;
    idle_in(); adsc_n = 0; addr = a; gwe_n = 0; din = seed; tick();
    exp_mem[a] = seed;
    for (int i = 1; i < 4; i++) begin
      idle_in(); adv_n = 0; gwe_n = 0; din = seed + WW'(i) * 36'h111; tick();
      exp_mem[seq_addr(a, i, il)] = din;
    end
    deselect();
  endtask

  task automatic rd_burst(input string req, input logic [AW-1:0] a, input logic il, input logic ft);
    lbo_n = il; ft_n = ft; oe_n = 0;
    idle_in(); adsp_n = 0; addr = a; tick();
    if (!ft) check_out(req, 1, exp_mem[seq_addr(a, 0, il)]);
    for (int i = 1; i < 4; i++) begin
      idle_in(); adv_n = 0; tick();
      check_out(req, 1, exp_mem[seq_addr(a, ft ? i - 1 : i, il)]);
    end
    idle_in(); tick();
    check_out({req, " hold"}, 1, exp_mem[seq_addr(a, 3, il)]);
    deselect();
  endtask

  task automatic t_reset;
    check_out("R14 reset", 0, '0);
  endtask

  task automatic t_fill;
    wr_burst(6'h08, 0, 36'h1_0000_0001);
    wr_burst(6'h14, 0, 36'h2_2000_0100);
    wr_burst(6'h04, 1, 36'h3_0300_0030);
    rd_burst("R5 R8 gwe write then pipelined linear read", 6'h08, 0, 1);
  endtask

  task automatic t_orders;
    rd_burst("R7 linear order from offset 1", 6'h15, 0, 1);
    rd_burst("R7 interleaved order from offset 1", 6'h15, 1, 1);
    rd_burst("R9 flow-through interleaved", 6'h15, 1, 0);
    rd_burst("R9 flow-through linear", 6'h05, 0, 0);
  endtask

  task automatic t_bytes;
    idle_in(); adsc_n = 0; addr = 6'h09; gwe_n = 1; bwe_n = 0; bw_n = 4'b1010;
    din = 36'hA_BCDE_F123; tick();
    for (int l = 0; l < 4; l++)
      if (!bw_n[l]) exp_mem[6'h09][l*9 +: 9] = din[l*9 +: 9];
    deselect();
    idle_in(); adsc_n = 0; addr = 6'h0A; gwe_n = 1; bwe_n = 1; bw_n = 4'b0000;
    din = 36'hF_FFFF_FFFF; tick();
    deselect();
    idle_in(); adsc_n = 0; addr = 6'h0B; gwe_n = 0; bwe_n = 1; bw_n = 4'b1111;
    din = 36'h5_A5A5_A5A5; tick();
    exp_mem[6'h0B] = din;
    deselect();
    rd_burst("R6 R5 lane masks, bwe high is read, gwe overrides", 6'h08, 0, 1);
  endtask

  task automatic t_adsp_ignores_we;
    ft_n = 1; oe_n = 0; lbo_n = 0;
    idle_in(); adsp_n = 0; adsc_n = 0; addr = 6'h0A; gwe_n = 0; din = 36'h0_DEAD_0000; tick();
    idle_in(); tick();
    check_out("R3 adsp edge reads despite write enables", 1, exp_mem[6'h0A]);
    deselect();
    rd_burst("R3 R4 memory unchanged after adsp", 6'h08, 0, 1);
  endtask

  task automatic t_ce0_rules;
    ft_n = 1; oe_n = 0; lbo_n = 0;
    idle_in(); adsp_n = 0; addr = 6'h14; tick();
    idle_in(); adsp_n = 0; ce0_n = 1; addr = 6'h08; tick();
    check_out("R2 first beat", 1, exp_mem[6'h14]);
    idle_in(); tick();
    check_out("R2 blocked adsp keeps address", 1, exp_mem[6'h14]);
    idle_in(); adsc_n = 0; ce0_n = 1; tick();
    check_out("R12 one read tail after deselect", 1, exp_mem[6'h14]);
    idle_in(); tick();
    check_out("R12 R2 off one cycle after adsc deselect", 0, '0);
  endtask

  task automatic t_select;
    ft_n = 1; oe_n = 0;
    idle_in(); adsp_n = 0; ce1 = 0; addr = 6'h08; tick();
    idle_in(); tick();
    check_out("R1 ce1 low deselects", 0, '0);
    idle_in(); adsc_n = 0; ce2_n = 1; addr = 6'h08; tick();
    idle_in(); tick();
    check_out("R1 ce2_n high deselects", 0, '0);
    idle_in(); adsc_n = 0; addr = 6'h14; tick();
    idle_in(); tick();
    check_out("R1 all enables active selects", 1, exp_mem[6'h14]);
    deselect();
  endtask

  task automatic t_oe_bw;
    ft_n = 1; oe_n = 0; lbo_n = 0;
    idle_in(); adsp_n = 0; addr = 6'h08; tick();
    idle_in(); tick();
    check_out("R8 read before oe toggle", 1, exp_mem[6'h08]);
    oe_n = 1; #1;
    check_out("R10 oe high disables at once", 0, '0);
    oe_n = 0; #1;
    check_out("R10 oe low drives again", 1, exp_mem[6'h08]);
    idle_in(); bw_n = 4'b0111; tick();
    check_out("R11 bw low blanks output", 0, '0);
    idle_in(); tick();
    check_out("R11 R6 output back, no write done", 1, exp_mem[6'h08]);
    deselect();
  endtask

  task automatic t_sleep;
    ft_n = 1; oe_n = 0; lbo_n = 0;
    idle_in(); adsp_n = 0; addr = 6'h14; tick();
    idle_in(); tick();
    check_out("R13 before sleep", 1, exp_mem[6'h14]);
    zz = 1; #1;
    check_out("R13 sleep disables output", 0, '0);
    idle_in(); adsc_n = 0; gwe_n = 0; addr = 6'h14; din = 36'h0_BAD0_BAD0; tick();
    idle_in(); adv_n = 0; gwe_n = 0; tick();
    check_out("R13 still off in sleep", 0, '0);
    zz = 0; idle_in(); #1;
    check_out("R13 output resumes", 1, exp_mem[6'h14]);
    tick();
    check_out("R13 burst address kept", 1, exp_mem[6'h14]);
    idle_in(); adv_n = 0; tick();
    idle_in(); tick();
    check_out("R13 R7 burst advances after wake", 1, exp_mem[6'h15]);
    deselect();
    rd_burst("R13 memory retained", 6'h14, 0, 1);
  endtask

  initial begin
    rst_n = 0; zz = 0; oe_n = 0; ft_n = 1; lbo_n = 1; addr = '0; din = '0;
    idle_in();
    @(negedge clk); @(negedge clk); @(negedge clk);
    t_reset();
    rst_n = 1;
    tick();
    t_reset();
    t_fill();
    t_orders();
    t_bytes();
    t_adsp_ignores_we();
    t_ce0_rules();
    t_select();
    t_oe_bw();
    t_sleep();
    summary();
    $finish;
  end
endmodule